// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that counts down on ticks of a slow clock and requests a system reset when its count runs out. Software controls it through three write-only registers. The first is a 16-bit key register. The other two configure the timer: a 3-bit division select and a 12-bit reload value.

Special key values do three jobs. One starts the timer. One reloads ("feeds") the count. One opens the two configuration registers for writing. Once started, the timer cannot be stopped by any write. Only a system reset clears it.

The slow clock arrives as a one-cycle `tick` enable in the bus clock domain. Register writes are single cycle: address, data and strobe are sampled on a rising clock edge. Address map:
- Address 0 is the key register.
- Address 1 is the division select, taken from data bits [2:0].
- Address 2 is the reload value, taken from data bits [11:0].

Top module: `keyguard_wdt`

## Requirements
- R1: Writing 16'hCCCC to address 0 starts the timer. After a system reset the count starts at 4095 and the division select is 0. The first reset pulse is therefore seen 4 × 4095 ticks after the start write.
- R2: After a system reset the timer is stopped and `wd_reset` is low. No pulse appears until a start write. A system reset in mid-run stops the timer again.
- R3: After a feed, `wd_reset` is pulsed for exactly one cycle. The pulse comes D × max(L,1) ticks after the feed, where D is the division and L is the reload value. It is visible in the cycle after the edge of the last tick.
- R4: Writing 16'h5555 to address 0 opens the configuration registers. While they are open, address 1 takes data bits [2:0] and address 2 takes data bits [11:0]. Higher data bits are ignored.
- R5: A write to address 1 or 2 while the registers are closed has no effect.
- R6: Any key write other than 16'h5555 closes the registers, including a feed (16'hAAAA).
- R7: The division is 4 shifted left by the select value, saturating at 256. Selects 6 and 7 both divide by 256.
- R8: Once started, the timer cannot be stopped by any key value or register write.
- R9: When a pulse is issued, the count reloads from the reload register and keeps running. Without a feed, pulses repeat every D × max(L,1) ticks.
- R10: A feed (16'hAAAA) or a start write clears the tick divider. The next count step therefore comes a full division period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 key, 1 division select, 2 reload |
| wr_data | input | 16 | Write data |
| tick | input | 1 | One-cycle enable per slow-clock period |
| wd_reset | output | 1 | One-cycle reset request |

## Verification
The bench measures the exact tick count from feed to pulse for several pairs of select and reload value. The set includes select 6 and 7, reload 0, and data with stray upper bits. A divider without saturation, a count that expires one step early or late, or a field sliced from the wrong bits would each show up as a wrong interval.

Writes made while the registers are closed, and writes made after a stray key or a feed has relocked them, must leave the interval unchanged. A lock flag that is never cleared would change the interval.

A feed in the middle of a division period must restart the full interval. A divider that is not cleared would fire several ticks early.

The bench also checks three more behaviours:
- Stray keys must not stop the timer.
- A second pulse must follow a full period after the first without a feed.
- A mid-run system reset must stop the timer and restore the default count.

// File: rtl/keyguard_pkg.sv
// Shared constants for the key-protected watchdog: register addresses and
// the key values that start, feed and unlock the timer.
package keyguard_pkg;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_KEY = 2'd0;
    localparam logic [ADDR_W-1:0] A_PSEL = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;

    localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
endpackage

// File: rtl/keyguard_regs.sv
// Register file and key decoder for the watchdog.
// Holds the sticky run flag, the configuration lock, the division select
// and the reload value. It emits one-cycle feed and start strobes.
// Assumes writes are single-cycle and synchronous to clk.
module keyguard_regs
    import keyguard_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output logic              run,
    output logic [PSEL_W-1:0] psel,
    output logic [CNT_W-1:0]  reload,
    output logic              feed,
    output logic              start
);
    logic key_wr;
    logic open_q;

    // Decode key writes into strobes.
    always_comb begin
        key_wr = wr_en && (wr_addr == A_KEY);
        feed   = key_wr && (wr_data == KEY_FEED);
        start  = key_wr && (wr_data == KEY_START);
    end

    // Sticky run flag, lock state and protected configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            open_q <= 1'b0;
            psel   <= '0;
            reload <= '1;
        end else if (wr_en) begin
            if (wr_addr == A_KEY) begin
                open_q <= (wr_data == KEY_OPEN);
                if (wr_data == KEY_START) begin
                    run <= 1'b1;
                end
            end else if (wr_addr == A_PSEL) begin
                if (open_q) begin
                    psel <= wr_data[PSEL_W-1:0];
                end
            end else if (wr_addr == A_RELOAD) begin
                if (open_q) begin
                    reload <= wr_data[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/keyguard_prescale.sv
// Tick divider for the watchdog.
// Counts slow-clock ticks and emits a one-cycle step every
// 2^min(psel+LOG_MIN, LOG_MAX) ticks. A clear restarts the division period.
// Assumes the tick input is already synchronous to clk.
module keyguard_prescale #(
    parameter int PSEL_W  = 3,
    parameter int LOG_MIN = 2,
    parameter int LOG_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              clear,
    input  logic [PSEL_W-1:0] psel,
    output logic              step
);
    localparam int NSEL  = 2 ** PSEL_W;
    localparam int DIV_W = LOG_MAX;

    logic [DIV_W-1:0] term_tab [NSEL];
    logic [DIV_W-1:0] div_q;

    // One terminal count per select value, saturated at the largest division.
    for (genvar g = 0; g < NSEL; g++) begin : g_term
        localparam int SH = ((g + LOG_MIN) > LOG_MAX) ? LOG_MAX : (g + LOG_MIN);
        assign term_tab[g] = DIV_W'((64'd1 << SH) - 64'd1);
    end

    // Step when the divider reaches (or passed, after a select change) its end.
    always_comb begin
        step = run && tick && !clear && (div_q >= term_tab[psel]);
    end

    // Divider counter: cleared by feed/start, wraps on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear) begin
            div_q <= '0;
        end else if (run && tick) begin
            div_q <= step ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyguard_count.sv
// Watchdog down-counter.
// It moves one count per step. When a step finds the count at 1 or 0, it
// issues a one-cycle pulse and reloads from the reload value. A load (feed)
// has priority over a step.
// Assumes step is a single-cycle strobe.
module keyguard_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             bite
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // The count is about to expire on this step.
    always_comb begin
        last = (cnt_q <= CNT_W'(1));
    end

    // Count, reload on feed or on expiry, and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            bite  <= 1'b0;
        end else if (load) begin
            cnt_q <= reload;
            bite  <= 1'b0;
        end else if (step) begin
            cnt_q <= last ? reload : cnt_q - 1'b1;
            bite  <= last;
        end else begin
            bite  <= 1'b0;
        end
    end
endmodule

// File: rtl/keyguard_wdt.sv
// Top of the key-protected watchdog.
// Ties the key decoder, the tick divider and the down-counter together.
// Assumes tick is a clk-synchronous enable derived from the slow clock.
module keyguard_wdt
    import keyguard_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int PSEL_W  = 3,
    parameter int LOG_MIN = 2,
    parameter int LOG_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    input  logic              tick,
    output logic              wd_reset
);
    logic              run_w;
    logic [PSEL_W-1:0] psel_w;
    logic [CNT_W-1:0]  reload_w;
    logic              feed_w;
    logic              start_w;
    logic              step_w;
    logic              clear_w;

    // The divider restarts on either a feed or a start.
    assign clear_w = feed_w | start_w;

    keyguard_regs #(
        .CNT_W (CNT_W),
        .PSEL_W(PSEL_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .run    (run_w),
        .psel   (psel_w),
        .reload (reload_w),
        .feed   (feed_w),
        .start  (start_w)
    );

    keyguard_prescale #(
        .PSEL_W (PSEL_W),
        .LOG_MIN(LOG_MIN),
        .LOG_MAX(LOG_MAX)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_w),
        .tick (tick),
        .clear(clear_w),
        .psel (psel_w),
        .step (step_w)
    );

    keyguard_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (feed_w),
        .step  (step_w),
        .reload(reload_w),
        .bite  (wd_reset)
    );
endmodule

// File: rtl/keyguard_wdt_chk.sv
// Assertion checker for the watchdog, bound to the top module.
// It keeps its own shadow of the lock state, built from the write port only.
module keyguard_wdt_chk
    import keyguard_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [KEY_W-1:0]  wr_data,
    input logic              wd_reset,
    input logic              run,
    input logic [PSEL_W-1:0] psel,
    input logic [CNT_W-1:0]  reload,
    input logic              feed,
    input logic              start,
    input logic              step
);
    logic open_sh;

    // Shadow of the lock state, seen from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_sh <= 1'b0;
        end else if (wr_en && wr_addr == A_KEY) begin
            open_sh <= (wr_data == KEY_OPEN);
        end
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |=> !wd_reset);

    assert_quiet_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !wd_reset);

    assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    assert_locked_psel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PSEL && !open_sh) |=> $stable(psel));

    assert_locked_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RELOAD && !open_sh) |=> $stable(reload));

    assert_clear_divider_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (feed || start) |=> !step);

    assert_pulse_from_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |-> $past(step));
endmodule

bind keyguard_wdt keyguard_wdt_chk #(
    .CNT_W (CNT_W),
    .PSEL_W(PSEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wd_reset(wd_reset),
    .run     (run_w),
    .psel    (psel_w),
    .reload  (reload_w),
    .feed    (feed_w),
    .start   (start_w),
    .step    (step_w)
);

// File: tb/keyguard_wdt_test.sv
`timescale 1ns/1ps
module keyguard_wdt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        tick = 1'b1;
    logic        wd_reset;

    int checks = 0;
    int fails = 0;
    int pulse_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    keyguard_wdt uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .wd_reset(wd_reset)
    );

    // Vector: {division-select data, reload data, expected ticks from feed to pulse}
    localparam logic [47:0] VEC [8] = '{
        48'h0000_0005_0014,  // div 4, reload 5 -> 20
        48'h0001_0003_0018,  // div 8, reload 3 -> 24
        48'h0002_0002_0020,  // div 16, reload 2 -> 32
        48'h0007_0001_0100,  // select 7 saturates at 256
        48'h0006_0001_0100,  // select 6 -> 256
        48'h0003_F004_0080,  // upper reload bits ignored: div 32 x 4 = 128
        48'hFFF9_0007_0038,  // only bits [2:0] of select: div 8 x 7 = 56
        48'h0000_0000_0004   // reload 0 acts as 1
    };

    always @(negedge clk) if (wd_reset) pulse_seen++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write takes exactly one rising edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts rising edges until a pulse is seen after one of them.
    task automatic wait_pulse(output int n);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (wd_reset) return;
        end
        n = -1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] r);
        wr(2'd0, 16'h5555); wr(2'd1, p); wr(2'd2, r); wr(2'd0, 16'hAAAA);
    endtask

    initial begin
        int n;
        int p0;
        idle(3);
        check(wd_reset == 1'b0, "R2 reset state", wd_reset, 0);
        rst_n = 1'b1;
        idle(1);
        p0 = pulse_seen;
        idle(300);
        check(pulse_seen == p0, "R2 no pulse before start", pulse_seen - p0, 0);

        // R1: start from the default count and select
        wr(2'd0, 16'hCCCC);
        wait_pulse(n);
        check(n == 16380, "R1 first timeout", n, 16380);
        @(negedge clk);
        check(wd_reset == 1'b0, "R3 single-cycle pulse", wd_reset, 0);
        wait_pulse(n);
        check(n == 16379, "R9 repeat without feed", n, 16379);

        // Table walk: R4, R7, R3
        foreach (VEC[k]) begin
            setup(VEC[k][47:32], VEC[k][31:16]);
            wait_pulse(n);
            check(n == int'(VEC[k][15:0]), $sformatf("R7 R4 R3 vector %0d", k), n, int'(VEC[k][15:0]));
        end

        // Base config: div 8, reload 5 -> 40
        setup(16'h0001, 16'h0005);
        wait_pulse(n);
        check(n == 40, "R4 base config", n, 40);

        // R5: locked writes ignored
        wr(2'd1, 16'h0007); wr(2'd2, 16'h00FF); wr(2'd0, 16'hAAAA);
        wait_pulse(n);
        check(n == 40, "R5 locked writes", n, 40);

        // R6: stray key relocks
        wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd2, 16'h0009); wr(2'd0, 16'hAAAA);
        wait_pulse(n);
        check(n == 40, "R6 stray key relock", n, 40);

        // R6: feed relocks
        wr(2'd0, 16'h5555); wr(2'd0, 16'hAAAA); wr(2'd1, 16'h0003); wr(2'd0, 16'hAAAA);
        wait_pulse(n);
        check(n == 40, "R6 feed relock", n, 40);

        // R10: mid-period feed restarts divider
        wr(2'd0, 16'hAAAA);
        idle(6);
        wr(2'd0, 16'hAAAA);
        wait_pulse(n);
        check(n == 40, "R10 divider cleared", n, 40);

        // R8: keys cannot stop it
        wr(2'd0, 16'hAAAA); wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF);
        wait_pulse(n);
        check(n == 38, "R8 still running", n, 38);

        // R2: mid-run system reset stops and restores defaults
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        p0 = pulse_seen;
        idle(300);
        check(pulse_seen == p0, "R2 stopped after reset", pulse_seen - p0, 0);
        wr(2'd0, 16'hCCCC);
        wait_pulse(n);
        check(n == 16380, "R1 defaults restored", n, 16380);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule